// File: doc/BRIEF.md
# SDRAM Bank Command Sequencer

This block sits on the controller side of a four-bank synchronous DRAM. It takes user access requests, each naming a bank, a row, a column, a direction and whether the bank should close itself after the access. It turns them into the command stream the memory expects: row open, column read or write (plain or self-closing), and row close. The sequencer records for every bank whether a row is open and which one. It keeps per-bank down-counters for the open-to-column delay, the minimum open time and the close-to-reopen delay, and it drives at most one command per clock on a registered command/address bus.

Requests enter a small in-order queue through a valid/ready handshake. Only the head of the queue may produce commands, so the oldest request always wins. Hits to an open row go straight to the column command. Misses close the row first, reopen it and then issue the column command. An explicit close aimed at a bank whose burst is still running cuts that burst short. When a self-closing access has a short burst, the block holds the column command back until the implied close can no longer fall inside the minimum open time. Refresh, power-up setup and data movement are handled elsewhere.

Top module: `sdram_bank_seq`

## Requirements
- R1: After reset the command bus carries the no-operation code 0 and `req_ready` is high.
- R2: A request to a bank with no open row first produces an open command (code 1) on that bank with the request row on `cmd_addr`, and the bank then counts as open.
- R3: A column command to a bank comes no earlier than T_RCD cycles after its open command, and exactly T_RCD cycles after it when nothing else holds it back.
- R4: A request whose row matches the open row of its bank produces only the column command, with no new open command.
- R5: A request to another row of an open bank produces a close command (code 4), then an open command exactly T_RP cycles later, then the column command T_RCD cycles after that; the close comes no earlier than T_RAS cycles after the earlier open.
- R6: After a self-closing column command at cycle c with burst length BL, the bank counts as closed, and the next open command to it comes exactly at c + BL + T_RP when a request is waiting.
- R7: A self-closing column command comes no earlier than T_RAS - BL cycles after the open command; with BL = 1 and no other hold-back it comes exactly then.
- R8: A close command to the bank whose burst is still running ends that burst, so the next column command is not held until the burst would have ended.
- R9: Two column commands are at least BL cycles apart unless the earlier burst was cut by R8; with back-to-back hits they are exactly BL apart.
- R10: Column commands appear in the order their requests were accepted.
- R11: Command codes are read 2, write 3, self-closing read 6, self-closing write 7; column commands carry the column in the low bits of `cmd_addr`; the burst length is 1 << `bl_code`.
- R12: `req_ready` is low while the request queue holds QDEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bl_code | input | 2 | Burst length select, length = 1 << code |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request queue can accept |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the bank after the burst |
| cmd_code | output | 3 | Command code (0 none, 1 open, 2/3 read/write, 4 close, 6/7 self-closing read/write) |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | ADDR_W | Row for open, column for column commands |

## Verification
The bench drives a first access to a closed bank, a hit to the open row, and a miss to another row of an open bank. Each yields a different command sequence (open+column, column alone, close+open+column), so a wrong hit/miss decision shows up directly. A self-closing access with burst length 1 is compared against a plain read: only the self-closing one may be delayed past T_RCD, which separates the stretch from the ordinary delay. A burst-8 read followed by a miss on the same bank shows whether the close cut the burst, and mixed-bank and queue-filling hits with bursts of 4 and 8 expose spacing, ordering and back-pressure errors. A bank model inside the bench also checks every command against the timing rules as it appears.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  localparam int CNT_W = 8;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_RDA = 3'd6,
    CMD_WRA = 3'd7
  } sdram_cmd_e;

  // burst length in cycles from the two-bit select
  function automatic cnt_t burst_cycles(input logic [1:0] code);
    return cnt_t'(1) << code;
  endfunction

  // value loaded into a down-counter so that the next command may follow
  // exactly 'gap' cycles later (counter reaches zero one cycle early because
  // the command itself is registered)
  function automatic cnt_t gap_load(input cnt_t gap);
    return (gap == '0) ? '0 : gap - cnt_t'(1);
  endfunction

  function automatic cnt_t cnt_step(input cnt_t c);
    return (c == '0) ? '0 : c - cnt_t'(1);
  endfunction

  // self-closing column is allowed once the implied close, BL cycles after
  // the column command, cannot precede the minimum open time
  function automatic logic ap_ras_met(input cnt_t ras_left, input cnt_t bl);
    return ras_left <= bl;
  endfunction

endpackage

// File: rtl/sdram_req_fifo.sv
module sdram_req_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [PTR_W:0]   level;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty = (level == '0);
  assign full  = (level == (PTR_W+1)'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push && !full) wr_ptr <= ptr_next(wr_ptr);
      if (pop && !empty) rd_ptr <= ptr_next(rd_ptr);
      case ({push && !full, pop && !empty})
        2'b10:   level <= level + (PTR_W+1)'(1);
        2'b01:   level <= level - (PTR_W+1)'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int T_RCD = 2,
  parameter int T_RAS = 5,
  parameter int T_RP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_pre,
  input  logic             do_col,
  input  logic             col_ap,
  input  logic [ROW_W-1:0] row_in,
  input  cnt_t             bl,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             rcd_done,
  output cnt_t             ras_left,
  output logic             rp_done
);
  cnt_t rcd_cnt, ras_cnt, rp_cnt;

  assign rcd_done = (rcd_cnt == '0);
  assign rp_done  = (rp_cnt == '0);
  assign ras_left = ras_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open  <= 1'b0;
      open_row <= '0;
      rcd_cnt  <= '0;
      ras_cnt  <= '0;
      rp_cnt   <= '0;
    end else begin
      rcd_cnt <= cnt_step(rcd_cnt);
      ras_cnt <= cnt_step(ras_cnt);
      rp_cnt  <= cnt_step(rp_cnt);
      if (do_act) begin
        is_open  <= 1'b1;
        open_row <= row_in;
        rcd_cnt  <= gap_load(cnt_t'(T_RCD));
        ras_cnt  <= gap_load(cnt_t'(T_RAS));
      end
      if (do_pre) begin
        is_open <= 1'b0;
        rp_cnt  <= gap_load(cnt_t'(T_RP));
      end
      if (do_col && col_ap) begin
        // close starts when the burst ends, reopen T_RP after that
        is_open <= 1'b0;
        rp_cnt  <= gap_load(bl + cnt_t'(T_RP));
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_pick.sv
module sdram_cmd_pick
  import sdram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int ADDR_W    = 12
) (
  input  logic                            head_valid,
  input  logic [BANK_W-1:0]               head_bank,
  input  logic [ROW_W-1:0]                head_row,
  input  logic [COL_W-1:0]                head_col,
  input  logic                            head_wr,
  input  logic                            head_ap,
  input  logic [NUM_BANKS-1:0]            bank_open,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0] open_row,
  input  logic [NUM_BANKS-1:0]            rcd_done,
  input  logic [NUM_BANKS-1:0]            rp_done,
  input  cnt_t [NUM_BANKS-1:0]            ras_left,
  input  logic                            burst_idle,
  input  cnt_t                            bl,
  output sdram_cmd_e                      nxt_cmd,
  output logic [BANK_W-1:0]               nxt_bank,
  output logic [ADDR_W-1:0]               nxt_addr,
  output logic                            pop
);
  logic row_hit, col_ok;

  assign row_hit = bank_open[head_bank] && (open_row[head_bank] == head_row);
  assign col_ok  = rcd_done[head_bank] && burst_idle &&
                   (!head_ap || ap_ras_met(ras_left[head_bank], bl));

  always_comb begin
    nxt_cmd  = CMD_NOP;
    nxt_bank = head_bank;
    nxt_addr = '0;
    pop      = 1'b0;
    if (head_valid) begin
      if (!bank_open[head_bank]) begin
        if (rp_done[head_bank]) begin
          nxt_cmd  = CMD_ACT;
          nxt_addr = ADDR_W'(head_row);
        end
      end else if (!row_hit) begin
        if (ras_left[head_bank] == '0) nxt_cmd = CMD_PRE;
      end else if (col_ok) begin
        if (head_wr) nxt_cmd = head_ap ? CMD_WRA : CMD_WR;
        else         nxt_cmd = head_ap ? CMD_RDA : CMD_RD;
        nxt_addr = ADDR_W'(head_col);
        pop      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdram_bank_seq.sv
module sdram_bank_seq
  import sdram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W,
  parameter int T_RCD     = 2,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 2,
  parameter int QDEPTH    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bl_code,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  input  logic              req_autopre,
  output logic [2:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr
);
  localparam int REQ_W = BANK_W + ROW_W + COL_W + 2;

  // request queue
  logic [REQ_W-1:0] q_din, q_dout;
  logic             q_empty, q_full, q_pop;

  logic [BANK_W-1:0] head_bank;
  logic [ROW_W-1:0]  head_row;
  logic [COL_W-1:0]  head_col;
  logic              head_wr, head_ap;

  assign q_din     = {req_bank, req_row, req_col, req_write, req_autopre};
  assign {head_bank, head_row, head_col, head_wr, head_ap} = q_dout;
  assign req_ready = !q_full;

  sdram_req_fifo #(.W(REQ_W), .DEPTH(QDEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (req_valid && req_ready),
    .pop   (q_pop),
    .din   (q_din),
    .dout  (q_dout),
    .empty (q_empty),
    .full  (q_full)
  );

  // per-bank state
  cnt_t bl;
  assign bl = burst_cycles(bl_code);

  logic [NUM_BANKS-1:0]            bank_open, rcd_done, rp_done, ras_zero;
  logic [NUM_BANKS-1:0][ROW_W-1:0] open_row;
  cnt_t [NUM_BANKS-1:0]            ras_left;
  logic [NUM_BANKS-1:0]            act_vec, pre_vec, col_vec;

  sdram_cmd_e        nxt_cmd;
  logic [BANK_W-1:0] nxt_bank;
  logic [ADDR_W-1:0] nxt_addr;

  always_comb begin
    for (int i = 0; i < NUM_BANKS; i++) begin
      act_vec[i]  = (nxt_cmd == CMD_ACT) && (nxt_bank == BANK_W'(i));
      pre_vec[i]  = (nxt_cmd == CMD_PRE) && (nxt_bank == BANK_W'(i));
      col_vec[i]  = q_pop && (nxt_bank == BANK_W'(i));
      ras_zero[i] = (ras_left[i] == '0);
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdram_bank_track #(
      .ROW_W (ROW_W),
      .T_RCD (T_RCD),
      .T_RAS (T_RAS),
      .T_RP  (T_RP)
    ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_act   (act_vec[g]),
      .do_pre   (pre_vec[g]),
      .do_col   (col_vec[g]),
      .col_ap   (head_ap),
      .row_in   (head_row),
      .bl       (bl),
      .is_open  (bank_open[g]),
      .open_row (open_row[g]),
      .rcd_done (rcd_done[g]),
      .ras_left (ras_left[g]),
      .rp_done  (rp_done[g])
    );
  end

  // shared data-burst window
  cnt_t              burst_left;
  logic [BANK_W-1:0] burst_bank;
  logic              burst_idle, burst_cut;

  assign burst_idle = (burst_left == '0);
  assign burst_cut  = (nxt_cmd == CMD_PRE) && (nxt_bank == burst_bank) && !burst_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_left <= '0;
      burst_bank <= '0;
    end else if (q_pop) begin
      burst_left <= gap_load(bl);
      burst_bank <= nxt_bank;
    end else if (burst_cut) begin
      burst_left <= '0;
    end else begin
      burst_left <= cnt_step(burst_left);
    end
  end

  sdram_cmd_pick #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .ADDR_W    (ADDR_W)
  ) u_pick (
    .head_valid (!q_empty),
    .head_bank  (head_bank),
    .head_row   (head_row),
    .head_col   (head_col),
    .head_wr    (head_wr),
    .head_ap    (head_ap),
    .bank_open  (bank_open),
    .open_row   (open_row),
    .rcd_done   (rcd_done),
    .rp_done    (rp_done),
    .ras_left   (ras_left),
    .burst_idle (burst_idle),
    .bl         (bl),
    .nxt_cmd    (nxt_cmd),
    .nxt_bank   (nxt_bank),
    .nxt_addr   (nxt_addr),
    .pop        (q_pop)
  );

  // registered command bus
  sdram_cmd_e cmd_q;
  assign cmd_code = cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= CMD_NOP;
      cmd_bank <= '0;
      cmd_addr <= '0;
    end else begin
      cmd_q    <= nxt_cmd;
      cmd_bank <= nxt_bank;
      cmd_addr <= nxt_addr;
    end
  end
endmodule

// File: rtl/sdram_bank_seq_chk.sv
module sdram_bank_seq_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           cmd_code,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [NUM_BANKS-1:0] rcd_done,
  input logic [NUM_BANKS-1:0] ras_zero,
  input logic                 burst_idle,
  input logic                 burst_cut,
  input logic                 q_full,
  input logic                 req_ready
);
  // bank state as it stood when the visible command was chosen
  logic [NUM_BANKS-1:0] open_q, rcd_q, ras_q;
  logic                 burst_q;
  logic                 is_col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= '0;
      rcd_q   <= '0;
      ras_q   <= '0;
      burst_q <= 1'b1;
    end else begin
      open_q  <= bank_open;
      rcd_q   <= rcd_done;
      ras_q   <= ras_zero;
      burst_q <= burst_idle;
    end
  end

  assign is_col = (cmd_code == 3'd2) || (cmd_code == 3'd3) ||
                  (cmd_code == 3'd6) || (cmd_code == 3'd7);

  a_r2_act_on_closed_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 3'd1) |-> !open_q[cmd_bank]);

  a_r3_col_after_rcd: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> rcd_q[cmd_bank]);

  a_r4_col_on_open_bank: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> open_q[cmd_bank]);

  a_r5_pre_after_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 3'd4) |-> ras_q[cmd_bank]);

  a_r9_col_outside_burst: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> burst_q);

  a_r8_cut_frees_window: assert property (@(posedge clk) disable iff (!rst_n)
    burst_cut |=> burst_idle);

  a_r12_no_ready_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !req_ready);
endmodule

bind sdram_bank_seq sdram_bank_seq_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BANK_W    (BANK_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_code   (cmd_code),
  .cmd_bank   (cmd_bank),
  .bank_open  (bank_open),
  .rcd_done   (rcd_done),
  .ras_zero   (ras_zero),
  .burst_idle (burst_idle),
  .burst_cut  (burst_cut),
  .q_full     (q_full),
  .req_ready  (req_ready)
);

// File: tb/sdram_bank_seq_tb_top.sv
module sdram_bank_seq_tb_top;
  localparam int ROW_W = 12;
  localparam int COL_W = 9;
  localparam int AW    = 12;
  localparam int TRCD  = 2;
  localparam int TRAS  = 5;
  localparam int TRP   = 2;
  localparam int QD    = 4;
  localparam int LOGN  = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]       bl_code = 2'd0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [1:0]       req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic             req_write = 1'b0;
  logic             req_autopre = 1'b0;
  logic [2:0]       cmd_code;
  logic [1:0]       cmd_bank;
  logic [AW-1:0]    cmd_addr;

  sdram_bank_seq #(
    .NUM_BANKS (4), .ROW_W (ROW_W), .COL_W (COL_W),
    .T_RCD (TRCD), .T_RAS (TRAS), .T_RP (TRP), .QDEPTH (QD)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .bl_code (bl_code),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_bank (req_bank), .req_row (req_row), .req_col (req_col),
    .req_write (req_write), .req_autopre (req_autopre),
    .cmd_code (cmd_code), .cmd_bank (cmd_bank), .cmd_addr (cmd_addr)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit saw_full = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // command log
  int lg_code [LOGN];
  int lg_bank [LOGN];
  int lg_addr [LOGN];
  int lg_cyc  [LOGN];
  int lg_n = 0;

  // behavioural bank model
  bit m_open [4];
  int m_act  [4];
  int m_ready[4];
  int m_burst_end = 0;
  int m_burst_bank = -1;

  function automatic int cur_bl();
    return 1 << bl_code;
  endfunction

  always @(negedge clk) begin
    if (rst_n && cmd_code != 3'd0) begin
      int b;
      b = int'(cmd_bank);
      if (lg_n < LOGN) begin
        lg_code[lg_n] = int'(cmd_code);
        lg_bank[lg_n] = b;
        lg_addr[lg_n] = int'(cmd_addr);
        lg_cyc[lg_n]  = cyc;
        lg_n++;
      end
      case (cmd_code)
        3'd1: begin
          check(!m_open[b], "R2 open only a closed bank", int'(m_open[b]), 0);
          check(cyc >= m_ready[b], "R6 reopen delay", cyc, m_ready[b]);
          m_open[b] = 1'b1;
          m_act[b]  = cyc;
        end
        3'd2, 3'd3, 3'd6, 3'd7: begin
          check(m_open[b], "R4 column to open bank", int'(m_open[b]), 1);
          check(cyc - m_act[b] >= TRCD, "R3 column after open", cyc - m_act[b], TRCD);
          check(cyc >= m_burst_end, "R9 burst not interrupted", cyc, m_burst_end);
          m_burst_end  = cyc + cur_bl();
          m_burst_bank = b;
          if (cmd_code[2]) begin
            check(cyc + cur_bl() - m_act[b] >= TRAS, "R7 self-close after min open time",
                  cyc + cur_bl() - m_act[b], TRAS);
            m_open[b]  = 1'b0;
            m_ready[b] = cyc + cur_bl() + TRP;
          end
        end
        3'd4: begin
          check(m_open[b], "R5 close an open bank", int'(m_open[b]), 1);
          check(cyc - m_act[b] >= TRAS, "R5 close after min open time", cyc - m_act[b], TRAS);
          m_open[b]  = 1'b0;
          m_ready[b] = cyc + TRP;
          if (b == m_burst_bank && m_burst_end > cyc) m_burst_end = cyc;
        end
        default: check(1'b0, "R11 command code", int'(cmd_code), 0);
      endcase
    end
  end

  function automatic int find(input int from, input int code, input int bank);
    for (int i = (from < 0 ? 0 : from); i < lg_n; i++)
      if (lg_code[i] == code && lg_bank[i] == bank) return i;
    return -1;
  endfunction

  function automatic int cy(input int i);
    return (i < 0) ? -1000 : lg_cyc[i];
  endfunction

  function automatic int ad(input int i);
    return (i < 0) ? -1 : lg_addr[i];
  endfunction

  // all tasks start and end at a falling edge
  task automatic push(input int b, input int row, input int col, input bit wr, input bit ap);
    req_valid   = 1'b1;
    req_bank    = 2'(b);
    req_row     = ROW_W'(row);
    req_col     = COL_W'(col);
    req_write   = wr;
    req_autopre = ap;
    while (!req_ready) begin
      saw_full = 1'b1;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check(cmd_code == 3'd0, "R1 command idle after reset", int'(cmd_code), 0);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
  endtask

  task automatic t_first_access();
    int s, a, r;
    s = lg_n;
    push(0, 5, 3, 1'b0, 1'b0);
    settle(20);
    a = find(s, 1, 0);
    r = find(s, 2, 0);
    check(a >= 0, "R2 open issued", a, s);
    check(ad(a) == 5, "R2 open carries row", ad(a), 5);
    check(cy(r) - cy(a) == TRCD, "R3 read exactly T_RCD after open", cy(r) - cy(a), TRCD);
    check(ad(r) == 3, "R11 read carries column", ad(r), 3);
  endtask

  task automatic t_row_hit();
    int s, r;
    s = lg_n;
    push(0, 5, 7, 1'b0, 1'b0);
    settle(20);
    r = find(s, 2, 0);
    check(find(s, 1, 0) < 0, "R4 no open on row hit", find(s, 1, 0), -1);
    check(lg_n - s == 1, "R4 single command on row hit", lg_n - s, 1);
    check(ad(r) == 7, "R4 hit column", ad(r), 7);
  endtask

  task automatic t_row_miss();
    int s, p, a, w;
    s = lg_n;
    push(0, 9, 1, 1'b1, 1'b0);
    settle(20);
    p = find(s, 4, 0);
    a = find(s, 1, 0);
    w = find(s, 3, 0);
    check(p >= 0 && p < a && a < w, "R5 close, open, write order", a, p + 1);
    check(cy(a) - cy(p) == TRP, "R5 open T_RP after close", cy(a) - cy(p), TRP);
    check(cy(w) - cy(a) == TRCD, "R5 write T_RCD after open", cy(w) - cy(a), TRCD);
    check(ad(a) == 9, "R5 new row", ad(a), 9);
    check(ad(w) == 1, "R11 write code and column", ad(w), 1);
  endtask

  task automatic t_self_close_stretch();
    int s, a1, r1, a2, r2;
    bl_code = 2'd0;
    s = lg_n;
    push(1, 2, 4, 1'b0, 1'b1);
    push(1, 2, 6, 1'b0, 1'b1);
    settle(30);
    a1 = find(s, 1, 1);
    r1 = find(s, 6, 1);
    a2 = find(r1 + 1, 1, 1);
    r2 = find(a2 + 1, 6, 1);
    check(cy(r1) - cy(a1) == TRAS - 1, "R7 stretched self-closing read", cy(r1) - cy(a1), TRAS - 1);
    check(cy(a2) - cy(r1) == 1 + TRP, "R6 reopen after self-close", cy(a2) - cy(r1), 1 + TRP);
    check(cy(r2) - cy(a2) == TRAS - 1, "R7 second stretched read", cy(r2) - cy(a2), TRAS - 1);
    check(find(s, 4, 1) < 0, "R6 no explicit close needed", find(s, 4, 1), -1);
  endtask

  task automatic t_burst_cut();
    int s, a, r1, p, r2;
    bl_code = 2'd3;
    s = lg_n;
    push(2, 1, 0, 1'b0, 1'b0);
    push(2, 4, 8, 1'b0, 1'b0);
    settle(40);
    a  = find(s, 1, 2);
    r1 = find(s, 2, 2);
    p  = find(s, 4, 2);
    r2 = find(r1 + 1, 2, 2);
    check(cy(r1) - cy(a) == TRCD, "R3 burst-8 read", cy(r1) - cy(a), TRCD);
    check(cy(p) - cy(a) == TRAS, "R5 close at min open time", cy(p) - cy(a), TRAS);
    check(cy(r2) - cy(r1) == TRAS + TRP, "R8 close cuts burst", cy(r2) - cy(r1), TRAS + TRP);
    check(ad(r2) == 8, "R8 new column", ad(r2), 8);
  endtask

  task automatic t_mixed_spacing();
    int s, a, c1, c2, c3;
    bl_code = 2'd2;
    s = lg_n;
    push(3, 0, 0, 1'b0, 1'b0);
    push(2, 4, 4, 1'b0, 1'b0);
    push(3, 0, 8, 1'b1, 1'b1);
    settle(40);
    a  = find(s, 1, 3);
    c1 = find(s, 2, 3);
    c2 = find(s, 2, 2);
    c3 = find(s, 7, 3);
    check(cy(c1) - cy(a) == TRCD, "R3 bank 3 read", cy(c1) - cy(a), TRCD);
    check(cy(c2) - cy(c1) == 4, "R9 burst-4 gap", cy(c2) - cy(c1), 4);
    check(cy(c3) - cy(c2) == 4, "R9 gap before self-closing write", cy(c3) - cy(c2), 4);
    check(c1 < c2 && c2 < c3, "R10 acceptance order", c2, c1 + 1);
    check(ad(c3) == 8, "R11 self-closing write column", ad(c3), 8);
  endtask

  task automatic t_queue_full();
    int s, k, last;
    bl_code = 2'd3;
    saw_full = 1'b0;
    s = lg_n;
    for (int i = 0; i < 6; i++) push(0, 9, 10 + i, 1'b0, 1'b0);
    check(saw_full, "R12 ready dropped with full queue", int'(saw_full), 1);
    settle(80);
    k = 0;
    last = -1;
    for (int i = s; i < lg_n; i++) begin
      if (lg_code[i] == 2 && lg_bank[i] == 0) begin
        check(lg_addr[i] == 10 + k, "R10 column order", lg_addr[i], 10 + k);
        if (last >= 0) check(lg_cyc[i] - last == 8, "R9 burst-8 gap", lg_cyc[i] - last, 8);
        last = lg_cyc[i];
        k++;
      end
    end
    check(k == 6, "R10 all queued reads issued", k, 6);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int b = 0; b < 4; b++) begin
      m_open[b] = 1'b0;
      m_act[b] = -100;
      m_ready[b] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_access();
    t_row_hit();
    t_row_miss();
    t_self_close_stretch();
    t_burst_cut();
    t_mixed_spacing();
    t_queue_full();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end
endmodule